// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block holds the program counter of a small processor core and the hidden stack of return addresses that goes with it. Each cycle in which the `step` input is high marks an instruction boundary. At that boundary the block either runs the control operation on `op` (advance, skip, jump, call, return, or load of the low byte) or, when an interrupt is pending and the stack has room, takes the interrupt instead. The PC is 10 to 12 bits wide and the stack holds 4 or 6 return addresses. Software cannot read or write the stack or its pointer.

Interrupt requests from three sources are latched when their enable bit is set. They stay latched until they are taken. A full stack holds every pending interrupt back, and the interrupt is taken at the first boundary after a return has freed a level. A call, however, always runs. When a call finds the stack full, it overwrites the oldest return address and sets a sticky overflow flag. A return with an empty stack does not move the pointer.

Top module: `pc_unit`

## Requirements
- R1: While reset is asserted and just after it is released: pc = 0x000, sp = 0, stk_empty = 1, stk_full = 0, stk_ovf = 0, irq_ack = 0.
- R2: On a step, op code 0 (sequential) sets pc to pc+1 and op code 1 (taken skip) sets pc to pc+2, both modulo 2^PC_W. The unused codes 6 and 7 behave like code 0.
- R3: On a step, op code 2 (jump) loads pc from imm_addr. Op code 3 (call) pushes pc+1 and then loads pc from imm_addr.
- R4: On a step, op code 5 (low load) sets pc[7:0] to low_byte and leaves the bits above bit 7 unchanged.
- R5: On a step, op code 4 (return, used for both subroutine and interrupt return) with a non-empty stack pops the most recently pushed address into pc and decrements sp.
- R6: When a step meets a pending interrupt and the stack is not full, the block acknowledges it in place of the presented op. It asserts irq_ack in that same cycle, one-hot with bit 0 = external, bit 1 = timer and bit 2 = converter done. It pushes the unexecuted pc and loads the vector 0x004, 0x008 or 0x00C respectively.
- R7: When several interrupts are pending, external wins over timer and timer wins over converter. The losers stay pending and are taken at later steps.
- R8: A request is latched only in a cycle where its enable bit is high. A masked request is never acknowledged. While stk_full is high, no acknowledge is issued and pending requests are kept. They are taken at the first step after a return has lowered sp.
- R9: A call with the stack full still executes. It overwrites the oldest stored address, sp stays at the stack depth, and stk_ovf goes high and stays high until reset.
- R10: A return with the stack empty leaves sp at 0 and loads pc with the address that the last pop vacated.
- R11: With step low, pc and sp hold and irq_ack stays 0. Request latching still takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 1 | Instruction boundary; the op is executed in this cycle |
| op | input | 3 | Control operation code (see R2 to R5) |
| imm_addr | input | PC_W | Full target address for jump and call |
| low_byte | input | 8 | New value for the low 8 PC bits |
| irq_req | input | 3 | Interrupt requests: bit 0 external, bit 1 timer, bit 2 converter |
| irq_en | input | 3 | Per-source enables, same bit order |
| pc | output | PC_W | Current program counter |
| sp | output | clog2(STK_DEPTH+1) | Number of valid stack entries |
| stk_full | output | 1 | sp equals STK_DEPTH |
| stk_empty | output | 1 | sp equals 0 |
| stk_ovf | output | 1 | Sticky: a push hit a full stack |
| irq_ack | output | 3 | One-hot acknowledge, valid in the step cycle it is taken |

## Verification
Two things can fall in the same cycle. A pending interrupt can meet a call or return at a step, and in that case the interrupt must take the slot and the op must not run. A return on a full stack can also meet a waiting interrupt, and in that case the return runs and the interrupt follows at the next step. The bench provokes both with random ops mixed with sparse random requests and enables, and with a directed run that fills the stack, raises a request and then returns. It judges each cycle by predicting irq_ack in the step cycle, then pc, sp and the status flags after the edge, from a reference model driven only by the requirements.

// File: rtl/pc_unit_pkg.sv
package pc_unit_pkg;

   // control operation codes presented with a step
   typedef enum logic [2:0] {
      OP_SEQ  = 3'd0,
      OP_SKIP = 3'd1,
      OP_JUMP = 3'd2,
      OP_CALL = 3'd3,
      OP_RET  = 3'd4,
      OP_LDLO = 3'd5
   } pc_op_e;

   localparam int IRQ_N = 3;   // external, timer, converter
   localparam int LOW_W = 8;   // width of the low-byte load

   // service address of interrupt source idx
   function automatic int vec_of(int idx);
      return (idx + 1) * 4;
   endfunction

endpackage

// File: rtl/pc_irq_arb.sv
module pc_irq_arb #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   input  logic [N-1:0] en,
   input  logic         grant_ok,
   output logic [N-1:0] ack
);

   logic [N-1:0] pend_q;
   logic         taken;

   // fixed priority: lowest index wins
   always_comb begin
      ack   = '0;
      taken = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (grant_ok && pend_q[i] && !taken) begin
            ack[i] = 1'b1;
            taken  = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~ack) | (req & en);
   end

endmodule

// File: rtl/pc_ret_stack.sv
module pc_ret_stack #(
   parameter int W = 12,
   parameter int D = 6
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   push,
   input  logic                   pop,
   input  logic [W-1:0]           push_data,
   output logic [W-1:0]           top_data,
   output logic [$clog2(D+1)-1:0] count,
   output logic                   full,
   output logic                   empty,
   output logic                   ovf
);

   localparam int IW = $clog2(D);
   localparam int CW = $clog2(D+1);
   localparam int SW = CW + 1;

   logic [IW-1:0]        base_q, base_inc, wr_idx, rd_idx, tgt_idx;
   logic [CW-1:0]        cnt_q;
   logic                 ovf_q;
   logic [D-1:0][W-1:0]  slots;

   assign full  = (cnt_q == CW'(D));
   assign empty = (cnt_q == '0);

   // ring index arithmetic, variant chosen by depth
   if ((D & (D - 1)) == 0) begin : g_pow2
      assign wr_idx   = base_q + IW'(cnt_q);
      assign rd_idx   = empty ? base_q : (base_q + IW'(cnt_q) - IW'(1));
      assign base_inc = base_q + IW'(1);
   end else begin : g_mod
      logic [SW-1:0] sum, sum_m1;
      assign sum      = SW'(base_q) + SW'(cnt_q);
      assign sum_m1   = sum - SW'(1);
      assign wr_idx   = (sum >= SW'(D)) ? IW'(sum - SW'(D)) : IW'(sum);
      assign rd_idx   = empty ? base_q :
                        ((sum_m1 >= SW'(D)) ? IW'(sum_m1 - SW'(D)) : IW'(sum_m1));
      assign base_inc = (base_q == IW'(D - 1)) ? '0 : base_q + IW'(1);
   end

   // a full push lands on the oldest entry
   assign tgt_idx = full ? base_q : wr_idx;

   for (genvar i = 0; i < D; i++) begin : g_slot
      logic [W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           q <= '0;
         else if (push && tgt_idx == IW'(i))   q <= push_data;
      end
      assign slots[i] = q;
   end

   assign top_data = slots[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
         ovf_q  <= 1'b0;
      end else if (push) begin
         if (full) begin
            base_q <= base_inc;
            ovf_q  <= 1'b1;
         end else begin
            cnt_q  <= cnt_q + CW'(1);
         end
      end else if (pop && !empty) begin
         cnt_q <= cnt_q - CW'(1);
      end
   end

   assign count = cnt_q;
   assign ovf   = ovf_q;

endmodule

// File: rtl/pc_next.sv
module pc_next
   import pc_unit_pkg::*;
#(
   parameter int W = 12,
   parameter int N = 3
) (
   input  logic [W-1:0]     pc_q,
   input  logic             step,
   input  logic [2:0]       op,
   input  logic [N-1:0]     ack,
   input  logic [W-1:0]     imm_addr,
   input  logic [LOW_W-1:0] low_byte,
   input  logic [W-1:0]     pop_data,
   output logic [W-1:0]     pc_d,
   output logic             push,
   output logic             pop,
   output logic [W-1:0]     push_data
);

   logic [W-1:0] vec;
   logic [W-1:0] inc1, inc2;

   assign inc1 = pc_q + W'(1);
   assign inc2 = pc_q + W'(2);

   always_comb begin
      vec = '0;
      for (int i = 0; i < N; i++)
         if (ack[i]) vec = W'(vec_of(i));
   end

   always_comb begin
      pc_d      = pc_q;
      push      = 1'b0;
      pop       = 1'b0;
      push_data = pc_q;
      if (|ack) begin
         push = 1'b1;
         pc_d = vec;
      end else if (step) begin
         case (pc_op_e'(op))
            OP_SKIP: pc_d = inc2;
            OP_JUMP: pc_d = imm_addr;
            OP_CALL: begin
               push      = 1'b1;
               push_data = inc1;
               pc_d      = imm_addr;
            end
            OP_RET: begin
               pop  = 1'b1;
               pc_d = pop_data;
            end
            OP_LDLO: pc_d = {pc_q[W-1:LOW_W], low_byte};
            default: pc_d = inc1;
         endcase
      end
   end

endmodule

// File: rtl/pc_unit.sv
module pc_unit
   import pc_unit_pkg::*;
#(
   parameter  int PC_W      = 12,
   parameter  int STK_DEPTH = 6,
   localparam int SP_W      = $clog2(STK_DEPTH + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 step,
   input  logic [2:0]           op,
   input  logic [PC_W-1:0]      imm_addr,
   input  logic [LOW_W-1:0]     low_byte,
   input  logic [IRQ_N-1:0]     irq_req,
   input  logic [IRQ_N-1:0]     irq_en,
   output logic [PC_W-1:0]      pc,
   output logic [SP_W-1:0]      sp,
   output logic                 stk_full,
   output logic                 stk_empty,
   output logic                 stk_ovf,
   output logic [IRQ_N-1:0]     irq_ack
);

   if (PC_W < 10 || PC_W > 12) begin : g_bad_width
      $error("pc_unit: PC_W must lie in 10..12");
   end
   if (STK_DEPTH != 4 && STK_DEPTH != 6) begin : g_bad_depth
      $error("pc_unit: STK_DEPTH must be 4 or 6");
   end

   logic [PC_W-1:0] pc_q, pc_d, push_data, pop_data;
   logic            push, pop;

   pc_irq_arb #(.N(IRQ_N)) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (irq_req),
      .en       (irq_en),
      .grant_ok (step && !stk_full),
      .ack      (irq_ack)
   );

   pc_ret_stack #(.W(PC_W), .D(STK_DEPTH)) u_stk (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .pop       (pop),
      .push_data (push_data),
      .top_data  (pop_data),
      .count     (sp),
      .full      (stk_full),
      .empty     (stk_empty),
      .ovf       (stk_ovf)
   );

   pc_next #(.W(PC_W), .N(IRQ_N)) u_nxt (
      .pc_q      (pc_q),
      .step      (step),
      .op        (op),
      .ack       (irq_ack),
      .imm_addr  (imm_addr),
      .low_byte  (low_byte),
      .pop_data  (pop_data),
      .pc_d      (pc_d),
      .push      (push),
      .pop       (pop),
      .push_data (push_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc_q <= '0;
      else        pc_q <= pc_d;
   end

   assign pc = pc_q;

endmodule

// File: rtl/pc_unit_chk.sv
module pc_unit_chk #(
   parameter  int PC_W      = 12,
   parameter  int STK_DEPTH = 6,
   localparam int SP_W      = $clog2(STK_DEPTH + 1)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            step,
   input logic [2:0]      op,
   input logic [PC_W-1:0] imm_addr,
   input logic [7:0]      low_byte,
   input logic [PC_W-1:0] pc,
   input logic [SP_W-1:0] sp,
   input logic            stk_full,
   input logic            stk_empty,
   input logic            stk_ovf,
   input logic [2:0]      irq_ack
);

   a_r6_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_ack));

   a_r6_vec_ext: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack[0] |=> pc == PC_W'(4));

   a_r6_vec_tmr: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack[1] |=> pc == PC_W'(8));

   a_r6_vec_adc: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack[2] |=> pc == PC_W'(12));

   a_r8_no_ack_full: assert property (@(posedge clk) disable iff (!rst_n)
      stk_full |-> irq_ack == 3'b000);

   a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(pc) && $stable(sp));

   a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      stk_ovf |=> stk_ovf);

   a_r3_target: assert property (@(posedge clk) disable iff (!rst_n)
      step && irq_ack == 3'b000 && (op == 3'd2 || op == 3'd3)
      |=> pc == $past(imm_addr));

   a_r4_page: assert property (@(posedge clk) disable iff (!rst_n)
      step && irq_ack == 3'b000 && op == 3'd5
      |=> pc[7:0] == $past(low_byte) && pc[PC_W-1:8] == $past(pc[PC_W-1:8]));

   a_r5_pop_dec: assert property (@(posedge clk) disable iff (!rst_n)
      step && irq_ack == 3'b000 && op == 3'd4 && !stk_empty
      |=> sp == $past(sp) - SP_W'(1));

   a_r10_empty_ret: assert property (@(posedge clk) disable iff (!rst_n)
      step && irq_ack == 3'b000 && op == 3'd4 && stk_empty
      |=> stk_empty && sp == '0);

endmodule

bind pc_unit pc_unit_chk #(.PC_W(PC_W), .STK_DEPTH(STK_DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .step      (step),
   .op        (op),
   .imm_addr  (imm_addr),
   .low_byte  (low_byte),
   .pc        (pc),
   .sp        (sp),
   .stk_full  (stk_full),
   .stk_empty (stk_empty),
   .stk_ovf   (stk_ovf),
   .irq_ack   (irq_ack)
);

// File: tb/pc_unit_tb.sv
module pc_unit_tb;
   localparam int PC_W    = 12;
   localparam int D       = 6;
   localparam int SP_W    = $clog2(D + 1);
   localparam int PC_MASK = (1 << PC_W) - 1;

   logic            clk = 1'b0, rst_n = 1'b0, step = 1'b0;
   logic [2:0]      op = '0;
   logic [PC_W-1:0] imm = '0;
   logic [7:0]      low = '0;
   logic [2:0]      req = '0, en = '0;
   logic [PC_W-1:0] pc;
   logic [SP_W-1:0] sp;
   logic            full, empty, ovf;
   logic [2:0]      ack;

   int n_chk = 0, n_fail = 0;

   // reference model state
   int     m_pc, m_base, m_cnt;
   int     m_mem [D];
   bit     m_ovf;
   bit [2:0] m_pend;

   always #4 clk = ~clk;

   pc_unit #(.PC_W(PC_W), .STK_DEPTH(D)) u_dut (
      .clk(clk), .rst_n(rst_n), .step(step), .op(op), .imm_addr(imm),
      .low_byte(low), .irq_req(req), .irq_en(en), .pc(pc), .sp(sp),
      .stk_full(full), .stk_empty(empty), .stk_ovf(ovf), .irq_ack(ack)
   );

   task automatic chk(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   function automatic void m_push(int v);
      if (m_cnt == D) begin
         m_mem[m_base] = v;
         m_base = (m_base + 1) % D;
         m_ovf  = 1'b1;
      end else begin
         m_mem[(m_base + m_cnt) % D] = v;
         m_cnt++;
      end
   endfunction

   function automatic int m_pop();
      if (m_cnt > 0) begin
         m_cnt--;
         return m_mem[(m_base + m_cnt) % D];
      end
      return m_mem[m_base];
   endfunction

   function automatic bit [2:0] m_ack(bit st);
      if (st && m_cnt < D)
         for (int i = 0; i < 3; i++)
            if (m_pend[i]) return 3'(1 << i);
      return 3'b000;
   endfunction

   function automatic void m_reset();
      m_pc = 0; m_base = 0; m_cnt = 0; m_ovf = 0; m_pend = 0;
      for (int i = 0; i < D; i++) m_mem[i] = 0;
   endfunction

   // one clock: drive at negedge, check ack mid-cycle, check state at next negedge
   task automatic cyc(bit st, int o, int im, int lo, bit [2:0] rq, bit [2:0] ee);
      bit [2:0] ea;
      string    tag;
      step = st; op = 3'(o); imm = PC_W'(im); low = 8'(lo); req = rq; en = ee;
      #1;
      ea = m_ack(st);
      if (ea != 0)                         tag = ea[0] ? "R6" : "R7";
      else if (!st)                        tag = "R11";
      else if (m_pend != 0 && m_cnt == D)  tag = "R8";
      else if (o == 3 && m_cnt == D)       tag = "R9";
      else if (o == 4)                     tag = (m_cnt == 0) ? "R10" : "R5";
      else if (o == 2 || o == 3)           tag = "R3";
      else if (o == 5)                     tag = "R4";
      else                                 tag = "R2";
      chk(tag, "irq_ack", int'(ack), int'(ea));
      if (ea != 0) begin
         m_push(m_pc);
         for (int i = 0; i < 3; i++) if (ea[i]) m_pc = (i + 1) * 4;
      end else if (st) begin
         case (o)
            1: m_pc = (m_pc + 2) & PC_MASK;
            2: m_pc = im & PC_MASK;
            3: begin m_push((m_pc + 1) & PC_MASK); m_pc = im & PC_MASK; end
            4: m_pc = m_pop();
            5: m_pc = (m_pc & ~255) | (lo & 255);
            default: m_pc = (m_pc + 1) & PC_MASK;
         endcase
      end
      m_pend = (m_pend & ~ea) | (rq & ee);
      @(posedge clk);
      @(negedge clk);
      chk(tag, "pc", int'(pc), m_pc);
      chk(tag, "sp", int'(sp), m_cnt);
      chk(tag, "stk_full", int'(full), int'(m_cnt == D));
      chk(tag, "stk_empty", int'(empty), int'(m_cnt == 0));
      chk(tag, "stk_ovf", int'(ovf), int'(m_ovf));
   endtask

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int p1;
      void'($urandom(32'd20240611));
      m_reset();
      repeat (3) @(negedge clk);
      chk("R1", "pc in reset", int'(pc), 0);
      chk("R1", "ack in reset", int'(ack), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "pc", int'(pc), 0);
      chk("R1", "sp", int'(sp), 0);
      chk("R1", "stk_empty", int'(empty), 1);
      chk("R1", "stk_full", int'(full), 0);
      chk("R1", "stk_ovf", int'(ovf), 0);

      // R2 sequential and skip
      cyc(1, 0, 0, 0, 0, 0);
      cyc(1, 1, 0, 0, 0, 0);
      chk("R2", "pc after seq+skip", int'(pc), 3);
      // R4 page-local load
      cyc(1, 2, 'h3A5, 0, 0, 0);
      cyc(1, 5, 0, 'h10, 0, 0);
      chk("R4", "pc after low load", int'(pc), 'h310);
      // R3 / R5 call and return
      cyc(1, 3, 'h100, 0, 0, 0);
      chk("R3", "pc after call", int'(pc), 'h100);
      cyc(1, 4, 0, 0, 0, 0);
      chk("R5", "pc after return", int'(pc), 'h311);
      // R9 overflow: one call more than the depth
      for (int k = 0; k <= D; k++) cyc(1, 3, 'h200 + k, 0, 0, 0);
      chk("R9", "stk_ovf", int'(ovf), 1);
      chk("R9", "sp at depth", int'(sp), D);
      // R8 request held while full, served after a return
      cyc(0, 0, 0, 0, 3'b001, 3'b001);
      cyc(1, 0, 0, 0, 0, 0);
      chk("R8", "pc no ack while full", int'(pc), 'h207);
      cyc(1, 4, 0, 0, 0, 0);
      cyc(1, 0, 0, 0, 0, 0);
      chk("R8", "pc after deferred ack", int'(pc), 4);
      // R10 drain past empty
      for (int k = 0; k < D + 1; k++) cyc(1, 4, 0, 0, 0, 0);
      p1 = int'(pc);
      cyc(1, 4, 0, 0, 0, 0);
      chk("R10", "sp on empty return", int'(sp), 0);
      chk("R10", "pc repeats on empty return", int'(pc), p1);
      // R7 priority among three simultaneous requests
      cyc(0, 0, 0, 0, 3'b111, 3'b111);
      cyc(1, 3, 'h0AA, 0, 0, 0);
      chk("R7", "first vector", int'(pc), 4);
      cyc(1, 0, 0, 0, 0, 0);
      chk("R7", "second vector", int'(pc), 8);
      cyc(1, 0, 0, 0, 0, 0);
      chk("R7", "third vector", int'(pc), 12);
      // R8 masked request is not latched
      cyc(0, 0, 0, 0, 3'b100, 3'b000);
      cyc(1, 0, 0, 0, 0, 0);
      chk("R8", "masked request ignored", int'(pc), 13);

      // constrained random phase
      for (int n = 0; n < 3000; n++) begin
         int r, o;
         bit [2:0] rq, ee;
         r = int'($urandom % 16);
         if      (r < 5)  o = 0;
         else if (r < 7)  o = 1;
         else if (r < 8)  o = 2;
         else if (r < 11) o = 3;
         else if (r < 14) o = 4;
         else if (r < 15) o = 5;
         else             o = int'($urandom % 8);
         for (int b = 0; b < 3; b++) rq[b] = ($urandom % 12) == 0;
         ee = 3'($urandom);
         cyc(($urandom % 8) != 0, o, int'($urandom), int'($urandom), rq, ee);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule